// File: doc/BRIEF.md
# No-Load Creep Threshold Detector

This block sits between an active-power sample source and an energy accumulator and keeps the meter from creeping when almost no power flows. Each valid signed power sample is reduced to its magnitude. That magnitude is compared with a small threshold picked by a 2-bit mode field. A sample that falls below the threshold is withheld from accumulation.

The block also raises a sticky no-load status flag, which software clears by writing a one. An interrupt output follows the flag while the interrupt enable input is high. The thresholds are fixed fractions of the full-scale power value and are computed at elaboration from parameters given in parts per million. With the defaults the full scale is 838,861, and the thresholds come out at 126 for mode 2'b01, 63 for mode 2'b10 and 31 for mode 2'b11.

Top module: `creep_guard`

## Requirements
- R1: After reset, `acc_valid`, `acc_en`, `nl_flag` and `irq` are all 0.
- R2: `acc_valid` is 1 in the cycle after each cycle with `smp_valid` = 1, and 0 otherwise. `acc_en` is never 1 while `acc_valid` is 0.
- R3: With mode 2'b00, detection is off. Every valid sample gives `acc_en` = 1, and `nl_flag` is not set by any sample.
- R4: The threshold is 126 for mode 2'b01, 63 for mode 2'b10 and 31 for mode 2'b11. These are the full-scale value 838,861 times 150, 75 and 37 ppm, rounded to the nearest integer.
- R5: The magnitude of the two's complement sample is compared with the threshold. A magnitude strictly below the threshold gives `acc_en` = 0, and a magnitude equal to or above it gives `acc_en` = 1. This holds for both positive and negative samples.
- R6: The most negative sample (-2^(SMP_W-1)) counts as the largest magnitude, so it always accumulates.
- R7: A valid sample that is below the threshold while detection is on sets `nl_flag` at the same edge that presents its `acc_en` = 0. The flag then stays at 1 through any later samples until it is cleared.
- R8: A cycle with `st_wr` = 1 and `st_wdata` = 1 clears `nl_flag`. A write with `st_wdata` = 0 leaves the flag unchanged. When a clear and a setting sample arrive in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when `nl_flag` = 1 and `irq_en` = 1.
- R10: The mode is taken from the same cycle as the valid sample, so a mode change applies from the next valid sample, including back-to-back samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W | Signed active-power sample |
| mode | input | 2 | Threshold select: 00 off, 01/10/11 high/mid/low threshold |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 1 | Status write data; 1 clears the flag |
| irq_en | input | 1 | Interrupt enable for the no-load flag |
| acc_valid | output | 1 | Registered copy of the sample strobe |
| acc_en | output | 1 | Accumulate this sample |
| nl_flag | output | 1 | Sticky no-load status |
| irq | output | 1 | No-load interrupt |

## Verification
The bench builds the block with its default parameters: a 24-bit sample and a full scale of 838,861. With these values the three thresholds land on the small integers 126, 63 and 31. That lets the vector table probe each threshold one LSB below it and exactly at it, for both signs. The 24-bit width also keeps the most negative sample, -8,388,608, in reach, where a naive negation would wrap to a small value. The directed tests cover the flag's set/clear race and mode changes between adjacent samples.

// File: rtl/nld_pkg.sv
package nld_pkg;

   localparam int MODE_W    = 2;
   localparam int NUM_MODES = 1 << MODE_W;

   typedef enum logic [MODE_W-1:0] {
      NL_OFF = 2'b00,
      NL_HI  = 2'b01,
      NL_MID = 2'b10,
      NL_LO  = 2'b11
   } nl_mode_e;

   // Rounded fraction of full scale, fraction given in parts per million.
   function automatic longint unsigned thr_calc(input longint unsigned full_scale,
                                                input longint unsigned ppm);
      longint unsigned prod;
      prod = full_scale * ppm + 64'd500000;
      return prod / 64'd1000000;
   endfunction

endpackage

// File: rtl/nld_thresh_sel.sv
module nld_thresh_sel #(
   parameter int unsigned SMP_W      = 24,
   parameter int unsigned FULL_SCALE = 838861,
   parameter int unsigned PPM_HI     = 150,
   parameter int unsigned PPM_MID    = 75,
   parameter int unsigned PPM_LO     = 37
) (
   input  logic [nld_pkg::MODE_W-1:0] mode,
   output logic [SMP_W-1:0]           thr,
   output logic                       det_on
);
   import nld_pkg::*;

   localparam longint unsigned MAG_LIMIT = 64'd1 << (SMP_W - 1);

   logic [SMP_W-1:0] thr_tab [NUM_MODES];

   for (genvar k = 0; k < NUM_MODES; k++) begin : g_thr
      if (k == 0) begin : g_off
         assign thr_tab[k] = '0;
      end else begin : g_on
         localparam longint unsigned PPM_K =
            (k == 1) ? PPM_HI : (k == 2) ? PPM_MID : PPM_LO;
         localparam longint unsigned THR_K = thr_calc(FULL_SCALE, PPM_K);
         if (THR_K == 0 || THR_K >= MAG_LIMIT) begin : g_bad
            $error("nld_thresh_sel: threshold for mode %0d out of range", k);
         end
         assign thr_tab[k] = SMP_W'(THR_K);
      end
   end

   if (FULL_SCALE >= MAG_LIMIT) begin : g_bad_fs
      $error("nld_thresh_sel: FULL_SCALE does not fit SMP_W");
   end

   assign thr    = thr_tab[mode];
   assign det_on = (mode != NL_OFF);

endmodule

// File: rtl/nld_mag_cmp.sv
module nld_mag_cmp #(
   parameter int unsigned SMP_W = 24
) (
   input  logic [SMP_W-1:0] smp,
   input  logic [SMP_W-1:0] thr,
   input  logic             det_on,
   output logic             below
);
   logic [SMP_W-1:0] mag;

   // Two's complement magnitude; the most negative code maps to 2^(W-1),
   // which still fits the unsigned width.
   always_comb begin
      if (smp[SMP_W-1]) mag = (~smp) + 1'b1;
      else              mag = smp;
   end

   assign below = det_on && (mag < thr);

   always_comb begin
      if (!det_on) assert (!below); // R3
   end

endmodule

// File: rtl/nld_status.sv
module nld_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic st_wr,
   input  logic st_wdata,
   input  logic irq_en,
   output logic nl_flag,
   output logic irq
);
   logic clr_req;

   assign clr_req = st_wr && st_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        nl_flag <= 1'b0;
      else if (set_req)  nl_flag <= 1'b1;
      else if (clr_req)  nl_flag <= 1'b0;
   end

   assign irq = nl_flag && irq_en;

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (nl_flag && !clr_req) |=> nl_flag); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> nl_flag); // R8
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> nl_flag); // R9

endmodule

// File: rtl/creep_guard.sv
module creep_guard #(
   parameter int unsigned SMP_W      = 24,
   parameter int unsigned FULL_SCALE = 838861,
   parameter int unsigned PPM_HI     = 150,
   parameter int unsigned PPM_MID    = 75,
   parameter int unsigned PPM_LO     = 37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [1:0]       mode,
   input  logic             st_wr,
   input  logic             st_wdata,
   input  logic             irq_en,
   output logic             acc_valid,
   output logic             acc_en,
   output logic             nl_flag,
   output logic             irq
);
   import nld_pkg::*;

   if (SMP_W < 8 || SMP_W > 48) begin : g_bad_w
      $error("creep_guard: SMP_W must lie in 8..48");
   end

   logic [SMP_W-1:0] thr;
   logic             det_on;
   logic             below;
   logic             set_req;

   nld_thresh_sel #(
      .SMP_W(SMP_W), .FULL_SCALE(FULL_SCALE),
      .PPM_HI(PPM_HI), .PPM_MID(PPM_MID), .PPM_LO(PPM_LO)
   ) u_thr (
      .mode   (mode),
      .thr    (thr),
      .det_on (det_on)
   );

   nld_mag_cmp #(.SMP_W(SMP_W)) u_cmp (
      .smp    (smp_data),
      .thr    (thr),
      .det_on (det_on),
      .below  (below)
   );

   assign set_req = smp_valid && below;

   nld_status u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (set_req),
      .st_wr    (st_wr),
      .st_wdata (st_wdata),
      .irq_en   (irq_en),
      .nl_flag  (nl_flag),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_en    <= 1'b0;
      end else begin
         acc_valid <= smp_valid;
         acc_en    <= smp_valid && !below;
      end
   end

   AST_EN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |-> acc_valid); // R2
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> acc_valid); // R2
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !acc_valid); // R2
   AST_OFF_ACCUMULATES: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && mode == NL_OFF) |=> acc_en); // R3
   AST_BLOCKED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_en) |-> nl_flag); // R7
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && st_wdata && !smp_valid) |=> !nl_flag); // R8

endmodule

// File: tb/tb_creep_guard.sv
module tb_creep_guard;
   localparam int W = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [W-1:0] smp_data = '0;
   logic [1:0] mode = 2'b00;
   logic st_wr = 1'b0, st_wdata = 1'b0, irq_en = 1'b0;
   logic acc_valid, acc_en, nl_flag, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   creep_guard dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .mode(mode), .st_wr(st_wr), .st_wdata(st_wdata), .irq_en(irq_en),
      .acc_valid(acc_valid), .acc_en(acc_en), .nl_flag(nl_flag), .irq(irq)
   );

   // {mode, sample, expected acc_en}
   localparam int NV = 16;
   localparam logic [26:0] VEC [NV] = '{
      {2'd0, 24'sd0,        1'b1},  // R3
      {2'd0, 24'sd5,        1'b1},  // R3
      {2'd1, 24'sd125,      1'b0},  // R4
      {2'd1, 24'sd126,      1'b1},  // R4
      {2'd1, -24'sd125,     1'b0},  // R5
      {2'd1, -24'sd126,     1'b1},  // R5
      {2'd2, 24'sd62,       1'b0},  // R4
      {2'd2, 24'sd63,       1'b1},  // R4
      {2'd2, -24'sd63,      1'b1},  // R5
      {2'd2, 24'sd0,        1'b0},  // R5
      {2'd3, 24'sd30,       1'b0},  // R4
      {2'd3, 24'sd31,       1'b1},  // R4
      {2'd3, -24'sd30,      1'b0},  // R5
      {2'd3, 24'sd8388607,  1'b1},  // R5
      {2'd1, 24'h800000,    1'b1},  // R6
      {2'd3, 24'h800000,    1'b1}   // R6
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] m, input logic [W-1:0] d);
      @(negedge clk);
      smp_valid = 1'b1; mode = m; smp_data = d;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      st_wr = 1'b1; st_wdata = 1'b1;
      @(negedge clk);
      st_wr = 1'b0; st_wdata = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 acc_valid", acc_valid, 1'b0);
      chk("R1 acc_en", acc_en, 1'b0);
      chk("R1 nl_flag", nl_flag, 1'b0);
      chk("R1 irq", irq, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][26:25], VEC[i][24:1]);
         chk("R2 acc_valid", acc_valid, 1'b1);
         chk($sformatf("R5 vector %0d acc_en", i), acc_en, VEC[i][0]);
         clear_flag();
         chk("R2 idle acc_valid", acc_valid, 1'b0);
         chk("R2 idle acc_en", acc_en, 1'b0);
      end

      // R3: mode off never sets the flag, even for zero power
      send(2'd0, 24'd0);
      chk("R3 flag stays clear", nl_flag, 1'b0);

      // R7: set and sticky across accumulating samples
      irq_en = 1'b0;
      send(2'd1, 24'd10);
      chk("R7 flag set", nl_flag, 1'b1);
      chk("R9 irq masked", irq, 1'b0);
      send(2'd1, 24'd5000);
      chk("R7 sticky acc_en", acc_en, 1'b1);
      chk("R7 sticky flag", nl_flag, 1'b1);
      irq_en = 1'b1;
      #1 chk("R9 irq on", irq, 1'b1);

      // R8: write of zero has no effect, write of one clears
      @(negedge clk); st_wr = 1'b1; st_wdata = 1'b0;
      @(negedge clk); st_wr = 1'b0;
      chk("R8 zero write keeps flag", nl_flag, 1'b1);
      clear_flag();
      chk("R8 cleared", nl_flag, 1'b0);
      chk("R9 irq off", irq, 1'b0);

      // R8: set wins over simultaneous clear
      @(negedge clk);
      smp_valid = 1'b1; mode = 2'd2; smp_data = 24'd1;
      st_wr = 1'b1; st_wdata = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0; st_wr = 1'b0; st_wdata = 1'b0;
      chk("R8 set wins", nl_flag, 1'b1);
      clear_flag();
      irq_en = 1'b0;

      // R10: mode change between back-to-back samples
      @(negedge clk);
      smp_valid = 1'b1; mode = 2'd1; smp_data = 24'd50;
      @(negedge clk);
      chk("R10 first acc_en", acc_en, 1'b0);
      mode = 2'd0;
      @(negedge clk);
      smp_valid = 1'b0;
      chk("R10 second acc_en", acc_en, 1'b1);
      chk("R10 second acc_valid", acc_valid, 1'b1);
      clear_flag();
      @(negedge clk);
      smp_valid = 1'b1; mode = 2'd3; smp_data = 24'd50;
      @(negedge clk);
      chk("R10 low thr acc_en", acc_en, 1'b1);
      mode = 2'd1;
      @(negedge clk);
      smp_valid = 1'b0;
      chk("R10 high thr acc_en", acc_en, 1'b0);
      chk("R7 flag from second", nl_flag, 1'b1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule